// File: doc/BRIEF.md
# Posted-CAS Command Decoder for a DDR2-Style Memory Device

This block sits behind the command pins of a DDR2-style memory device. On every rising clock edge it samples chip select, RAS, CAS and WE, classifies the cycle, and reports the class one cycle later. The classes are deselect, no-operation, activate, read, write, or "other". "Other" covers every command this block does not handle. The block also checks each accepted column command against three timing and usage rules and raises an error pulse when one is broken.

Read and write commands are posted. A column command accepted at some edge enters a delay line together with its bank and column address. It issues internally (`col_strobe`) after the programmed additive latency. The delay line then marks the start of the data window: for a read, AL + CL cycles after acceptance; for a write, one cycle earlier than that. AL and CL come from configuration inputs. They may only change while reset is held.

Top module: `ddr2_cmd_decoder`

## Requirements
- R1: When `cs_n` is high at a clock edge, `dec_cmd` shows code 0 (deselect) in the following cycle. RAS, CAS, WE, bank and address have no effect, and no error output rises.
- R2: When `cs_n` is low and RAS, CAS and WE are all high, `dec_cmd` shows code 1 (no-operation) in the following cycle. No error output rises.
- R3: With `cs_n` low, `{ras_n,cas_n,we_n}` is decoded as follows, each visible in the cycle after the edge:
  - 011 is activate (code 2).
  - 101 is read (code 3).
  - 100 is write (code 4).
  - Any other combination is code 5.
- R4: A read or write accepted at edge T pulses `col_strobe` in the cycle after edge T+AL. It carries that command's write flag, bank and column address. With AL = 0, this is the same cycle in which `dec_cmd` reports it.
- R5: A read accepted at edge T pulses `rd_win_start` for one cycle after edge T+AL+CL.
- R6: A write accepted at edge T pulses `wr_win_start` for one cycle after edge T+AL+CL-1.
- R7: A read or write accepted at the edge directly after another read or write pulses `tccd_err` in the cycle after its edge. The command still issues.
- R8: A read or write to a bank activated fewer than 3 edges earlier pulses `early_err` when AL = 0. When AL > 0, `early_err` never rises.
- R9: A read or write to a bank that has not been activated since reset pulses `bank_err`. The command still issues.
- R10: After reset, `dec_cmd` is 0 and every strobe, window and error output is low. Commands still in the delay line are discarded.
- R11: Column commands accepted on every second edge all issue, in acceptance order, with none lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; pins sampled on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe pin, active low |
| cas_n | input | 1 | Column strobe pin, active low |
| we_n | input | 1 | Write enable pin, active low |
| bank | input | 2 | Bank address |
| addr | input | 9 | Column part of the address bus |
| cfg_al | input | 3 | Additive latency, 0 to 5 |
| cfg_cl | input | 3 | CAS latency, 3 to 6 |
| dec_cmd | output | 3 | Class of the command sampled at the last edge |
| col_strobe | output | 1 | Internal issue of a posted column command |
| col_is_wr | output | 1 | Issued command is a write |
| col_bank | output | 2 | Bank of the issued command |
| col_addr | output | 9 | Column of the issued command |
| rd_win_start | output | 1 | Read data window begins |
| wr_win_start | output | 1 | Write data window begins |
| tccd_err | output | 1 | Column commands closer than two clocks |
| bank_err | output | 1 | Column command to a bank never activated |
| early_err | output | 1 | Column command inside the activate delay with AL = 0 |

## Verification
A delay-line stage that drops or shifts its contents appears at the ports as a missing or misplaced `col_strobe` or window pulse. It shows up exactly AL, AL+CL or AL+CL-1 cycles after the offending command, so the stimulus covers several AL and CL pairs to reach every tap. A wrong open-bank or age state per bank shows only on the next column command to that bank, as a wrong `bank_err` or `early_err`. For that reason, commands to recently activated and never-activated banks are mixed densely. A stale previous-command flag is seen within one cycle as a wrong `tccd_err`.

// File: rtl/ddr2_cmd_pkg.sv
package ddr2_cmd_pkg;

    localparam int BANK_W = 2;
    localparam int COL_W  = 9;
    localparam int AL_W   = 3;
    localparam int CL_W   = 3;
    localparam int CMD_W  = 3;

    typedef enum logic [CMD_W-1:0] {
        CMD_DESEL = 3'd0,
        CMD_NOP   = 3'd1,
        CMD_ACT   = 3'd2,
        CMD_RD    = 3'd3,
        CMD_WR    = 3'd4,
        CMD_OTHER = 3'd5
    } cmd_e;

    typedef struct packed {
        logic              valid;
        logic              is_wr;
        logic [BANK_W-1:0] bank;
        logic [COL_W-1:0]  col;
    } colcmd_t;

    function automatic cmd_e classify(input logic cs_n, input logic ras_n,
                                      input logic cas_n, input logic we_n);
        cmd_e c;
        if (cs_n) begin
            c = CMD_DESEL;
        end else begin
            case ({ras_n, cas_n, we_n})
                3'b111:  c = CMD_NOP;
                3'b011:  c = CMD_ACT;
                3'b101:  c = CMD_RD;
                3'b100:  c = CMD_WR;
                default: c = CMD_OTHER;
            endcase
        end
        return c;
    endfunction

    function automatic logic is_column(input cmd_e c);
        return (c == CMD_RD) || (c == CMD_WR);
    endfunction

endpackage

// File: rtl/ddr2_pin_decode.sv
module ddr2_pin_decode
    import ddr2_cmd_pkg::*;
(
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [BANK_W-1:0] bank,
    input  logic [COL_W-1:0]  addr,
    output cmd_e              cmd,
    output colcmd_t           col
);
    always_comb begin
        cmd       = classify(cs_n, ras_n, cas_n, we_n);
        col.valid = is_column(cmd);
        col.is_wr = (cmd == CMD_WR);
        col.bank  = bank;
        col.col   = addr;
    end
endmodule

// File: rtl/ddr2_bank_guard.sv
module ddr2_bank_guard
    import ddr2_cmd_pkg::*;
#(
    parameter int TRCD_CYC = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  cmd_e              cmd,
    input  logic [BANK_W-1:0] bank,
    input  logic              al_zero,
    output logic              tccd_err,
    output logic              bank_err,
    output logic              early_err
);
    localparam int NUM_BANKS = 1 << BANK_W;
    localparam int AGE_W     = $clog2(TRCD_CYC) + 1;
    localparam int AGE_SAT   = TRCD_CYC - 1;

    logic [NUM_BANKS-1:0] open_vec;
    logic [NUM_BANKS-1:0] young_vec;
    logic                 prev_col;
    logic                 col_now;

    assign col_now = is_column(cmd);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic             open_r;
        logic [AGE_W-1:0] age_r;

        always_ff @(posedge clk) begin
            if (rst) begin
                open_r <= 1'b0;
                age_r  <= '0;
            end else if (cmd == CMD_ACT && bank == BANK_W'(b)) begin
                open_r <= 1'b1;
                age_r  <= '0;
            end else if (age_r < AGE_W'(AGE_SAT)) begin
                age_r  <= age_r + 1'b1;
            end
        end

        assign open_vec[b]  = open_r;
        assign young_vec[b] = (age_r < AGE_W'(AGE_SAT));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_col  <= 1'b0;
            tccd_err  <= 1'b0;
            bank_err  <= 1'b0;
            early_err <= 1'b0;
        end else begin
            prev_col  <= col_now;
            tccd_err  <= col_now && prev_col;
            bank_err  <= col_now && !open_vec[bank];
            early_err <= col_now && open_vec[bank] && young_vec[bank] && al_zero;
        end
    end
endmodule

// File: rtl/ddr2_col_pipe.sv
module ddr2_col_pipe
    import ddr2_cmd_pkg::*;
#(
    parameter int MAX_AL = 5,
    parameter int MAX_CL = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  colcmd_t         col_in,
    input  logic [AL_W-1:0] al,
    input  logic [CL_W-1:0] cl,
    output colcmd_t         issue,
    output logic            rd_start,
    output logic            wr_start
);
    localparam int DEPTH = MAX_AL + MAX_CL + 1;
    localparam int IDX_W = $clog2(DEPTH);
    localparam int SUM_W = IDX_W + 1;

    colcmd_t stage [DEPTH];

    logic [SUM_W-1:0] iss_i;
    logic [SUM_W-1:0] rd_i;
    logic [SUM_W-1:0] wr_i;
    colcmd_t          rd_tap;
    colcmd_t          wr_tap;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < DEPTH; k++) stage[k] <= '0;
        end else begin
            stage[0] <= col_in;
            for (int k = 1; k < DEPTH; k++) stage[k] <= stage[k-1];
        end
    end

    always_comb begin
        iss_i  = SUM_W'(al);
        rd_i   = SUM_W'(al) + SUM_W'(cl);
        wr_i   = rd_i - 1'b1;
        issue  = (iss_i < SUM_W'(DEPTH)) ? stage[iss_i[IDX_W-1:0]] : '0;
        rd_tap = (rd_i  < SUM_W'(DEPTH)) ? stage[rd_i[IDX_W-1:0]]  : '0;
        wr_tap = (rd_i != '0 && wr_i < SUM_W'(DEPTH)) ? stage[wr_i[IDX_W-1:0]] : '0;
        rd_start = rd_tap.valid && !rd_tap.is_wr;
        wr_start = wr_tap.valid && wr_tap.is_wr;
    end
endmodule

// File: rtl/ddr2_cmd_decoder.sv
module ddr2_cmd_decoder
    import ddr2_cmd_pkg::*;
#(
    parameter int TRCD_CYC = 3,
    parameter int MAX_AL   = 5,
    parameter int MAX_CL   = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [BANK_W-1:0] bank,
    input  logic [COL_W-1:0]  addr,
    input  logic [AL_W-1:0]   cfg_al,
    input  logic [CL_W-1:0]   cfg_cl,
    output logic [CMD_W-1:0]  dec_cmd,
    output logic              col_strobe,
    output logic              col_is_wr,
    output logic [BANK_W-1:0] col_bank,
    output logic [COL_W-1:0]  col_addr,
    output logic              rd_win_start,
    output logic              wr_win_start,
    output logic              tccd_err,
    output logic              bank_err,
    output logic              early_err
);
    cmd_e    cmd_now;
    cmd_e    cmd_q;
    colcmd_t col_now;
    colcmd_t col_iss;

    ddr2_pin_decode u_decode (
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n),
        .bank  (bank),
        .addr  (addr),
        .cmd   (cmd_now),
        .col   (col_now)
    );

    ddr2_bank_guard #(.TRCD_CYC(TRCD_CYC)) u_guard (
        .clk       (clk),
        .rst       (rst),
        .cmd       (cmd_now),
        .bank      (bank),
        .al_zero   (cfg_al == '0),
        .tccd_err  (tccd_err),
        .bank_err  (bank_err),
        .early_err (early_err)
    );

    ddr2_col_pipe #(.MAX_AL(MAX_AL), .MAX_CL(MAX_CL)) u_pipe (
        .clk      (clk),
        .rst      (rst),
        .col_in   (col_now),
        .al       (cfg_al),
        .cl       (cfg_cl),
        .issue    (col_iss),
        .rd_start (rd_win_start),
        .wr_start (wr_win_start)
    );

    always_ff @(posedge clk) begin
        if (rst) cmd_q <= CMD_DESEL;
        else     cmd_q <= cmd_now;
    end

    assign dec_cmd    = cmd_q;
    assign col_strobe = col_iss.valid;
    assign col_is_wr  = col_iss.is_wr;
    assign col_bank   = col_iss.bank;
    assign col_addr   = col_iss.col;
endmodule

// File: rtl/ddr2_cmd_checker.sv
module ddr2_cmd_checker (
    input logic       clk,
    input logic       rst,
    input logic       cs_n,
    input logic       ras_n,
    input logic       cas_n,
    input logic       we_n,
    input logic [2:0] cfg_al,
    input logic [2:0] dec_cmd,
    input logic       col_strobe,
    input logic       tccd_err,
    input logic       bank_err,
    input logic       early_err
);
    logic pin_col;
    logic seen_col;

    assign pin_col = !cs_n && ras_n && !cas_n;

    always_ff @(posedge clk) begin
        if (rst) seen_col <= 1'b0;
        else     seen_col <= pin_col;
    end

    // R1
    a_r1_deselect_ignored: assert property (@(posedge clk) disable iff (rst)
        cs_n |=> (dec_cmd == 3'd0) && !tccd_err && !bank_err && !early_err);

    // R2
    a_r2_nop_quiet: assert property (@(posedge clk) disable iff (rst)
        (!cs_n && ras_n && cas_n && we_n) |=> (dec_cmd == 3'd1) && !tccd_err && !bank_err && !early_err);

    // R4
    a_r4_zero_al_issue: assert property (@(posedge clk) disable iff (rst)
        (cfg_al == 3'd0 && (dec_cmd == 3'd3 || dec_cmd == 3'd4)) |-> col_strobe);

    // R7
    a_r7_tccd_flag: assert property (@(posedge clk) disable iff (rst)
        (pin_col && seen_col) |=> tccd_err);

    // R8
    a_r8_posted_never_early: assert property (@(posedge clk) disable iff (rst)
        (cfg_al != 3'd0) |-> !early_err);
endmodule

bind ddr2_cmd_decoder ddr2_cmd_checker u_checker (
    .clk        (clk),
    .rst        (rst),
    .cs_n       (cs_n),
    .ras_n      (ras_n),
    .cas_n      (cas_n),
    .we_n       (we_n),
    .cfg_al     (cfg_al),
    .dec_cmd    (dec_cmd),
    .col_strobe (col_strobe),
    .tccd_err   (tccd_err),
    .bank_err   (bank_err),
    .early_err  (early_err)
);

// File: tb/ddr2_cmd_decoder_tb.sv
module ddr2_cmd_decoder_tb;
    localparam int CLK_P = 10;
    localparam int TRCD  = 3;
    localparam int RING  = 64;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [1:0] bank = '0;
    logic [8:0] addr = '0;
    logic [2:0] cfg_al = '0, cfg_cl = 3'd3;
    logic [2:0] dec_cmd;
    logic       col_strobe, col_is_wr, rd_win_start, wr_win_start;
    logic [1:0] col_bank;
    logic [8:0] col_addr;
    logic       tccd_err, bank_err, early_err;

    ddr2_cmd_decoder u_dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .bank(bank), .addr(addr), .cfg_al(cfg_al), .cfg_cl(cfg_cl),
        .dec_cmd(dec_cmd), .col_strobe(col_strobe), .col_is_wr(col_is_wr),
        .col_bank(col_bank), .col_addr(col_addr), .rd_win_start(rd_win_start),
        .wr_win_start(wr_win_start), .tccd_err(tccd_err), .bank_err(bank_err),
        .early_err(early_err)
    );

    always #(CLK_P/2) clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    int e = 0;
    int last_col = -10;
    bit bank_open [4];
    int act_edge  [4];

    int exp_dec [RING];
    bit exp_tccd [RING], exp_berr [RING], exp_early [RING];
    bit exp_stb [RING], exp_swr [RING], exp_rd [RING], exp_wr [RING];
    int exp_sbank [RING], exp_scol [RING];

    function automatic int code_of(input logic c, input logic r, input logic ca, input logic w);
        if (c) return 0;
        if (r && ca && w) return 1;
        if (!r && ca && w) return 2;
        if (r && !ca && w) return 3;
        if (r && !ca && !w) return 4;
        return 5;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s at edge %0d: actual=%0d expected=%0d", tag, e, act, expv);
        end
    endtask

    task automatic clear_slot(input int s);
        exp_dec[s] = 0; exp_tccd[s] = 0; exp_berr[s] = 0; exp_early[s] = 0;
        exp_stb[s] = 0; exp_swr[s] = 0; exp_rd[s] = 0; exp_wr[s] = 0;
        exp_sbank[s] = 0; exp_scol[s] = 0;
    endtask

    task automatic check_slot(input int s);
        chk(dec_cmd == exp_dec[s], "R1/R2/R3 dec_cmd", dec_cmd, exp_dec[s]);
        chk(tccd_err == exp_tccd[s], "R7 tccd_err", tccd_err, exp_tccd[s]);
        chk(bank_err == exp_berr[s], "R9 bank_err", bank_err, exp_berr[s]);
        chk(early_err == exp_early[s], "R8 early_err", early_err, exp_early[s]);
        chk(col_strobe == exp_stb[s], "R4 R11 col_strobe", col_strobe, exp_stb[s]);
        if (exp_stb[s]) begin
            chk(col_is_wr == exp_swr[s], "R4 col_is_wr", col_is_wr, exp_swr[s]);
            chk(int'(col_bank) == exp_sbank[s], "R4 R11 col_bank", col_bank, exp_sbank[s]);
            chk(int'(col_addr) == exp_scol[s], "R4 R11 col_addr", col_addr, exp_scol[s]);
        end
        chk(rd_win_start == exp_rd[s], "R5 rd_win_start", rd_win_start, exp_rd[s]);
        chk(wr_win_start == exp_wr[s], "R6 wr_win_start", wr_win_start, exp_wr[s]);
        clear_slot(s);
    endtask

    task automatic do_reset(input int al, input int cl);
        @(negedge clk);
        rst = 1'b1; cs_n = 1'b1; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1;
        cfg_al = 3'(al); cfg_cl = 3'(cl);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < RING; i++) clear_slot(i);
        for (int b = 0; b < 4; b++) begin bank_open[b] = 0; act_edge[b] = -100; end
        last_col = -10;
        e = 0;
        check_slot(0); // R10: reset state
    endtask

    task automatic issue(input logic c, input logic r, input logic ca, input logic w,
                         input logic [1:0] b, input logic [8:0] a);
        int n, code, al, cl;
        cs_n = c; ras_n = r; cas_n = ca; we_n = w; bank = b; addr = a;
        n = e + 1; al = int'(cfg_al); cl = int'(cfg_cl);
        code = code_of(c, r, ca, w);
        exp_dec[n % RING] = code;
        if (code == 2) begin
            bank_open[b] = 1; act_edge[b] = n;
        end else if (code == 3 || code == 4) begin
            exp_tccd[n % RING]  = (last_col == n - 1);
            exp_berr[n % RING]  = !bank_open[b];
            exp_early[n % RING] = bank_open[b] && al == 0 && (n - act_edge[b]) < TRCD;
            last_col = n;
            exp_stb[(n + al) % RING]   = 1;
            exp_swr[(n + al) % RING]   = (code == 4);
            exp_sbank[(n + al) % RING] = int'(b);
            exp_scol[(n + al) % RING]  = int'(a);
            if (code == 3) exp_rd[(n + al + cl) % RING] = 1;
            else           exp_wr[(n + al + cl - 1) % RING] = 1;
        end
        @(negedge clk);
        e = n;
        check_slot(e % RING);
    endtask

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) issue(1, 1, 1, 1, 0, 0);
    endtask

    task automatic random_cmd();
        int r;
        logic [1:0] b;
        logic [8:0] a;
        r = int'($urandom % 16);
        b = 2'($urandom);
        a = 9'($urandom);
        if (r < 2)       issue(1, 1'($urandom), 1'($urandom), 1'($urandom), b, a); // R1
        else if (r < 4)  issue(0, 1, 1, 1, b, a);                                 // R2
        else if (r < 7)  issue(0, 0, 1, 1, b, a);
        else if (r < 11) issue(0, 1, 0, 1, b, a);
        else if (r < 14) issue(0, 1, 0, 0, b, a);
        else begin
            case ($urandom % 4)
                0: issue(0, 0, 0, 0, b, a);
                1: issue(0, 0, 0, 1, b, a);
                2: issue(0, 0, 1, 0, b, a);
                default: issue(0, 1, 1, 0, b, a);
            endcase
        end
    endtask

    initial begin
        #(CLK_P * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));

        // Directed, AL=0 CL=3
        do_reset(0, 3);
        issue(0, 1, 0, 1, 2'd0, 9'h011);   // R9: bank never activated
        issue(0, 0, 1, 1, 2'd1, 9'h000);   // activate bank 1
        issue(0, 1, 0, 1, 2'd1, 9'h0a5);   // R8: one edge after activate
        issue(0, 1, 1, 1, 2'd3, 9'h1ff);   // R2 with junk address
        issue(0, 1, 0, 0, 2'd1, 9'h055);   // write, three edges after activate
        issue(0, 1, 0, 0, 2'd1, 9'h056);   // R7: back-to-back
        idle(14);

        // Directed, AL=2 CL=4: posted, no early flag (R8), spaced bursts (R11)
        do_reset(2, 4);
        issue(0, 0, 1, 1, 2'd2, 9'h000);
        issue(0, 1, 0, 1, 2'd2, 9'h101);
        issue(1, 0, 0, 0, 2'd0, 9'h000);   // R1 deselect with junk pins
        issue(0, 1, 0, 0, 2'd2, 9'h102);
        issue(0, 1, 1, 1, 2'd0, 9'h000);
        issue(0, 1, 0, 1, 2'd2, 9'h103);
        idle(14);

        // Reset with commands in flight drops them (R10)
        do_reset(5, 6);
        issue(0, 0, 1, 1, 2'd0, 9'h000);
        issue(0, 1, 0, 1, 2'd0, 9'h077);
        do_reset(5, 6);
        idle(14);

        // Random across configurations
        for (int s = 0; s < 8; s++) begin
            do_reset(int'($urandom % 6), 3 + int'($urandom % 4));
            for (int i = 0; i < 400; i++) random_cmd();
            idle(14);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule